// File: doc/BRIEF.md
# Six-Pin GPIO Port with Wake-on-Change

This block is the general-purpose I/O port of a small 8-bit microcontroller core. It holds one output data latch and one direction latch for each of six pins. The core writes the output latches through the port register. It loads the direction latches only through a separate direction-write strobe, which copies the working register. No read path exists for the direction latches. A port read does not return the latches. It returns the pin levels after a two-flop synchronizer, so a pin that the port drives high but that is pulled low externally reads as 0.

Pin 3 is input-only. It can also serve as the external reset input. Pins given to an alternate function read as 0. Pins 0, 1, 3 and 4 share one enable that turns on both their weak pull-ups and their wake-on-change. When pin 3 is the reset input, its pull-up is forced on and it takes no part in wake detection. A wake request is raised when an enabled pin differs from the snapshot taken at the last port read. The request stays up until the next read.

Top module: `gpio_wake_port`

## Requirements
- R1: After reset, every direction latch is 1, so `pad_oe_o` is 0. `wake_o` is 0 and `rd_data_o` bits 7:6 are 0.
- R2: On the cycle after `dir_wr_i`, the direction latch holds `wdata_i[5:0]`. Otherwise it is unchanged. For pins other than 3, `pad_oe_o[i]` is the inverse of direction bit i (0 = drive, 1 = high-impedance).
- R3: `pad_oe_o[3]` and `pad_out_o[3]` are 0 at all times, whatever the direction latch and output latch hold.
- R4: `rd_data_o[5:0]` shows the `pad_in_i` levels two clock edges after they are applied, whatever the direction and output latches hold. `rd_data_o[7:6]` is always 0.
- R5: A pin whose `alt_mask_i` bit is 1 reads as 0. Pin 3 reads as 0 while `pin3_rst_i` is 1.
- R6: `pull_en_o` bits 0, 1 and 4 equal `pullwake_en_i`. Bit 3 is `pullwake_en_i` OR `pin3_rst_i`. Bits 2 and 5 are 0.
- R7: With `pullwake_en_i` at 1, a synchronized level on pin 0, 1, 3 or 4 that differs from the snapshot sets `wake_o` on the next edge. `wake_o` then holds until an edge with `port_rd_i`. That edge clears `wake_o` and copies the synchronized pins into the snapshot. The snapshot is 0 after reset.
- R8: Pins 2 and 5 never raise a wake. Pin 3 raises none while `pin3_rst_i` is 1. While `pullwake_en_i` is 0, no wake is raised.
- R9: `port_wr_i` loads `wdata_i[5:0]` into the output latches and ignores bits 7:6. The latches hold their value until the next write. `pad_out_o` shows the latches for every pin except 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wdata_i | input | 8 | Working-register value used by both write strobes |
| port_wr_i | input | 1 | Write strobe for the output latches |
| dir_wr_i | input | 1 | Write strobe for the direction latches |
| port_rd_i | input | 1 | Port read strobe (takes the wake snapshot) |
| alt_mask_i | input | 6 | Pins assigned to an alternate function |
| pullwake_en_i | input | 1 | Shared pull-up and wake enable |
| pin3_rst_i | input | 1 | Pin 3 serves as the external reset input |
| pad_in_i | input | 6 | Pad input levels |
| pad_out_o | output | 6 | Pad output data |
| pad_oe_o | output | 6 | Pad output enables, 1 = drive |
| pull_en_o | output | 6 | Weak pull-up enables |
| rd_data_o | output | 8 | Port read data |
| wake_o | output | 1 | Wake request |

## Verification
The assertions check on every cycle that both write strobes land in the pad controls one edge later, with pin 3 never driven. They also check that a raised wake holds until a read, that a read clears it, that masked pins read as zero, and that no wake starts while the shared enable is off. The bench scenarios cover what needs history or the external pin picture. These are the two-edge read latency, a pin held low against its own driver, snapshot comparisons across several reads, and the exclusion of pins 2, 5 and reset-mode pin 3 from wake detection.

// File: rtl/gpio_wake_port.sv
module gpio_wake_port #(
  parameter int NPINS = 6,
  parameter int DW    = 8,
  parameter int INPIN = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DW-1:0]    wdata_i,
  input  logic             port_wr_i,
  input  logic             dir_wr_i,
  input  logic             port_rd_i,
  input  logic [NPINS-1:0] alt_mask_i,
  input  logic             pullwake_en_i,
  input  logic             pin3_rst_i,
  input  logic [NPINS-1:0] pad_in_i,
  output logic [NPINS-1:0] pad_out_o,
  output logic [NPINS-1:0] pad_oe_o,
  output logic [NPINS-1:0] pull_en_o,
  output logic [DW-1:0]    rd_data_o,
  output logic             wake_o
);
  localparam logic [NPINS-1:0] IN_ONLY = NPINS'(1) << INPIN;
  localparam logic [NPINS-1:0] SHARED  = NPINS'(6'b011011);

  logic [NPINS-1:0] dir_q, lat_q, sync1_q, sync2_q, snap_q;
  logic [NPINS-1:0] rst_pin, wake_pins;

  assign rst_pin   = pin3_rst_i ? IN_ONLY : '0;
  assign wake_pins = pullwake_en_i ? (SHARED & ~rst_pin) : '0;

  assign pad_oe_o  = ~dir_q & ~IN_ONLY;
  assign pad_out_o = lat_q & ~IN_ONLY;
  assign pull_en_o = (pullwake_en_i ? SHARED : '0) | rst_pin;
  assign rd_data_o = {{(DW-NPINS){1'b0}}, sync2_q & ~alt_mask_i & ~rst_pin};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '1;
      lat_q   <= '0;
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pad_in_i;
      sync2_q <= sync1_q;
      if (dir_wr_i)  dir_q <= wdata_i[NPINS-1:0];
      if (port_wr_i) lat_q <= wdata_i[NPINS-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
      wake_o <= 1'b0;
    end else if (port_rd_i) begin
      snap_q <= sync2_q;
      wake_o <= 1'b0;
    end else if (|((sync2_q ^ snap_q) & wake_pins)) begin
      wake_o <= 1'b1;
    end
  end
endmodule

// File: rtl/gpio_wake_port_chk.sv
module gpio_wake_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] wdata_i,
  input logic       port_wr_i,
  input logic       dir_wr_i,
  input logic       port_rd_i,
  input logic [5:0] alt_mask_i,
  input logic       pullwake_en_i,
  input logic [5:0] pad_out_o,
  input logic [5:0] pad_oe_o,
  input logic [7:0] rd_data_o,
  input logic       wake_o
);
  // R2
  dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dir_wr_i |=> pad_oe_o == (~$past(wdata_i[5:0]) & 6'b110111));
  // R9
  lat_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    port_wr_i |=> pad_out_o == ($past(wdata_i[5:0]) & 6'b110111));
  // R7
  wake_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_o && !port_rd_i) |=> wake_o);
  // R7
  wake_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    port_rd_i |=> !wake_o);
  // R8
  wake_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pullwake_en_i && !wake_o) |=> !wake_o);
  // R5
  alt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rd_data_o & {2'b11, alt_mask_i}) == 0);
endmodule

bind gpio_wake_port gpio_wake_port_chk i_chk (
  .clk(clk), .rst_n(rst_n), .wdata_i(wdata_i), .port_wr_i(port_wr_i),
  .dir_wr_i(dir_wr_i), .port_rd_i(port_rd_i), .alt_mask_i(alt_mask_i),
  .pullwake_en_i(pullwake_en_i), .pad_out_o(pad_out_o), .pad_oe_o(pad_oe_o),
  .rd_data_o(rd_data_o), .wake_o(wake_o));

// File: tb/test_gpio_wake_port.sv
module test_gpio_wake_port;
  logic clk = 0, rst_n = 0;
  logic [7:0] wdata = 0;
  logic port_wr = 0, dir_wr = 0, port_rd = 0, pw_en = 0, p3rst = 0;
  logic [5:0] alt = 0, pad = 0;
  logic [5:0] pad_out, pad_oe, pull_en;
  logic [7:0] rd_data;
  logic wake;

  int checks = 0, fails = 0;
  logic [5:0] m_dir, m_lat, m_s1, m_s2, m_snap;
  logic m_wake;

  gpio_wake_port i_gpio_wake_port (
    .clk(clk), .rst_n(rst_n), .wdata_i(wdata), .port_wr_i(port_wr),
    .dir_wr_i(dir_wr), .port_rd_i(port_rd), .alt_mask_i(alt),
    .pullwake_en_i(pw_en), .pin3_rst_i(p3rst), .pad_in_i(pad),
    .pad_out_o(pad_out), .pad_oe_o(pad_oe), .pull_en_o(pull_en),
    .rd_data_o(rd_data), .wake_o(wake));

  always #2 clk = ~clk;

  function automatic logic [5:0] f_wmask(logic en, logic r3);
    return en ? (6'b011011 & ~(r3 ? 6'b001000 : 6'b0)) : 6'b0;
  endfunction
  function automatic logic [7:0] f_rd(logic [5:0] s, logic [5:0] a, logic r3);
    return {2'b00, s & ~a & ~(r3 ? 6'b001000 : 6'b0)};
  endfunction
  function automatic logic [5:0] f_pull(logic en, logic r3);
    return (en ? 6'b011011 : 6'b0) | (r3 ? 6'b001000 : 6'b0);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R2", {26'b0, pad_oe & 6'b110111}, {26'b0, ~m_dir & 6'b110111});
    chk("R3", {30'b0, pad_oe[3], pad_out[3]}, 32'b0);
    chk("R9", {26'b0, pad_out}, {26'b0, m_lat & 6'b110111});
    chk("R4/R5", {24'b0, rd_data}, {24'b0, f_rd(m_s2, alt, p3rst)});
    chk("R6", {26'b0, pull_en}, {26'b0, f_pull(pw_en, p3rst)});
    chk("R7/R8", {31'b0, wake}, {31'b0, m_wake});
  endtask

  task automatic step();
    logic [5:0] s2o;
    @(posedge clk);
    s2o = m_s2;
    if (port_rd) begin m_snap = s2o; m_wake = 0; end
    else if (|((s2o ^ m_snap) & f_wmask(pw_en, p3rst))) m_wake = 1;
    m_s2 = m_s1; m_s1 = pad;
    if (dir_wr) m_dir = wdata[5:0];
    if (port_wr) m_lat = wdata[5:0];
    #1;
    check_all();
  endtask

  task automatic idle(int n);
    port_wr = 0; dir_wr = 0; port_rd = 0;
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    m_dir = '1; m_lat = 0; m_s1 = 0; m_s2 = 0; m_snap = 0; m_wake = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1", {24'b0, pad_oe, wake, 1'b0}, 32'b0);
    chk("R1", {30'b0, rd_data[7:6]}, 32'b0);
    rst_n = 1;
    idle(2);

    // R4: driven high, held low externally reads 0
    wdata = 8'h00; dir_wr = 1; step();
    wdata = 8'hFF; dir_wr = 0; port_wr = 1; step();
    port_wr = 0; pad = 6'b000000; idle(3);
    chk("R4", {24'b0, rd_data}, 32'h0);
    chk("R9", {26'b0, pad_out}, 32'h37);
    pad = 6'b110111; idle(2);
    chk("R4", {24'b0, rd_data}, 32'h37);

    // R7 wake on pin 1 change, hold, clear
    pw_en = 1; pad = 0; idle(3);
    port_rd = 1; step(); port_rd = 0;
    pad = 6'b000010; idle(2);
    chk("R7", {31'b0, wake}, 32'b0);
    idle(1);
    chk("R7", {31'b0, wake}, 32'b1);
    pad = 0; idle(4);
    chk("R7", {31'b0, wake}, 32'b1);
    port_rd = 1; step(); port_rd = 0;
    chk("R7", {31'b0, wake}, 32'b0);

    // R8: pins 2, 5 and reset-mode pin 3 never wake
    p3rst = 1; idle(1); port_rd = 1; step(); port_rd = 0;
    pad = 6'b101100; idle(5);
    chk("R8", {31'b0, wake}, 32'b0);
    p3rst = 0; pw_en = 0; pad = 6'b011011; idle(5);
    chk("R8", {31'b0, wake}, 32'b0);
    pad = 0; idle(3);

    // R5 alternate mask
    alt = 6'b000101; pad = 6'b111111; idle(3);
    chk("R5", {24'b0, rd_data}, 32'h3A);
    alt = 0;

    // random phase
    for (int i = 0; i < 3000; i++) begin
      wdata   = 8'($urandom);
      port_wr = ($urandom % 6) == 0;
      dir_wr  = ($urandom % 6) == 0;
      port_rd = ($urandom % 8) == 0;
      if (($urandom % 4) == 0) pad = 6'($urandom);
      if (($urandom % 16) == 0) alt = 6'($urandom);
      if (($urandom % 16) == 0) pw_en = 1'($urandom);
      if (($urandom % 32) == 0) p3rst = 1'($urandom);
      step();
    end
    idle(2);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule